// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block carries data words from one clock domain into a second, unrelated clock domain. A producer pushes a word by raising `wr_inc` with the word on `wr_data` while `wr_full` is low. A consumer in the other domain sees the oldest stored word on `rd_data` whenever `rd_empty` is low, and takes it by raising `rd_inc`. The words are kept in an internal register array of `DEPTH` entries, where `DEPTH` is a power of two.

Each side keeps its own position counter. The counter is one bit wider than the array address and is held in two forms: plain binary, used to address the array, and reflected Gray code, which is the only form that leaves its domain. The Gray value is re-timed into the opposite domain through a chain of at least two flops. Each side compares its own next pointer against that delayed copy to form its flag, and stores the flag in a register. Because the copy always lags the real pointer, `wr_full` and `rd_empty` can stay asserted a few cycles too long. They can never clear too early.

Each domain has its own asynchronous active-low reset. That reset clears the domain's pointers, its flag and the synchronizer chain that feeds it.

Top module: `dcf_fifo`

## Requirements
- R1: After reset is released, `rd_empty` reads 1 and `wr_full` reads 0.
- R2: Words leave on `rd_data` in exactly the order in which they were accepted on `wr_data`. The Nth read returns the Nth accepted write, across the two clocks.
- R3: A `wr_inc` seen at a write-clock edge while `wr_full` is 1 is discarded. The write pointer does not move, no array entry changes, and `wr_full` stays 1.
- R4: An `rd_inc` seen at a read-clock edge while `rd_empty` is 1 is discarded. The read pointer does not move, and `rd_empty` stays 1.
- R5: With no reads in progress, `wr_full` is 1 after the write-clock edge that accepts the DEPTH-th outstanding word. It is 0 while fewer than DEPTH words are outstanding.
- R6: With no writes in flight, `rd_empty` is 1 after the read-clock edge that takes the last stored word.
- R7: The flags never understate: whenever `rd_empty` is 0 at least one word is stored, and whenever `wr_full` is 0 at least one entry is free.
- R8: A single write into an idle empty FIFO leaves `rd_empty` at 1 for at least one read edge after the write edge, and clears it no later than the fourth read-clock falling edge after that write edge. The same bound holds for `wr_full` after a single read, counted in write-clock falling edges.
- R9: Whenever a Gray pointer register changes, exactly one of its bits flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset of the write domain |
| wr_inc | input | 1 | Push request, taken at the rising edge when `wr_full` is 0 |
| wr_data | input | DATA_W | Word to push |
| wr_full | output | 1 | Registered flag: no free entry, as seen by the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset of the read domain |
| rd_inc | input | 1 | Pop request, taken at the rising edge when `rd_empty` is 0 |
| rd_data | output | DATA_W | Oldest stored word, valid while `rd_empty` is 0 |
| rd_empty | output | 1 | Registered flag: nothing stored, as seen by the read side |

## Verification
A read pointer that drifts by even one step shows up at the next pop as a word out of sequence on `rd_data`. It also upsets the timing of `rd_empty` after the FIFO drains. A write pointer that moves while full overwrites a stored word. The reference queue then sees the wrong value, at the latest when the FIFO is emptied. A flag that clears early is caught on the same falling edge, because the reference occupancy is compared with both flags on every cycle of each clock. A broken synchronizer chain or comparison shows up in the flag-clear window measured in R8, within four cycles.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  // Selects which status flag a pointer block produces.
  typedef enum logic {SIDE_WR = 1'b0, SIDE_RD = 1'b1} side_e;

  // Binary to reflected Gray, on a zero-extended 32-bit value.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray back to binary, on a zero-extended 32-bit value.
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Gray image of a pointer exactly one lap ahead: the top two bits of a
  // pw-bit Gray value are inverted.
  function automatic logic [31:0] lap_ahead(input logic [31:0] g, input int unsigned pw);
    return g ^ (32'd3 << (pw - 2));
  endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      for (int i = NS - 1; i > 0; i--) begin
        chain[i] <= chain[i-1];
      end
      chain[0] <= d;
    end
  end

  assign q = chain[NS-1];
endmodule

// File: rtl/dcf_ptr.sv
`timescale 1ns/1ps
module dcf_ptr
  import dcf_pkg::*;
#(
  parameter int    PW   = 5,
  parameter side_e SIDE = SIDE_WR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic [PW-1:0] peer_sync,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] gray_q,
  output logic          flag_q,
  output logic          accept
);
  localparam logic FLAG_RST = (SIDE == SIDE_RD);

  logic [PW-1:0] bin_nxt;
  logic [PW-1:0] gray_nxt;
  logic          flag_nxt;

  assign accept   = inc & ~flag_q;
  assign bin_nxt  = bin_q + PW'(accept);
  assign gray_nxt = PW'(bin_to_gray(32'(bin_nxt)));

  generate
    if (SIDE == SIDE_WR) begin : g_full
      assign flag_nxt = (gray_nxt == PW'(lap_ahead(32'(peer_sync), PW)));
    end else begin : g_empty
      assign flag_nxt = (gray_nxt == peer_sync);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      flag_q <= FLAG_RST;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= gray_nxt;
      flag_q <= flag_nxt;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
  parameter int DATA_W = 8,
  parameter int AW     = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DATA_W-1:0] cells [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_inc,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_inc,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // Named internal events, exposed for the bound checker.
  logic [PW-1:0] w_bin, w_gray, r_bin, r_gray;
  logic [PW-1:0] wq_gray;   // write pointer as seen in the read domain
  logic [PW-1:0] rq_gray;   // read pointer as seen in the write domain
  logic          wr_accept, rd_accept;

  dcf_ptr #(.PW(PW), .SIDE(SIDE_WR)) u_wptr (
    .clk(wr_clk), .rst_n(wr_rst_n), .inc(wr_inc), .peer_sync(rq_gray),
    .bin_q(w_bin), .gray_q(w_gray), .flag_q(wr_full), .accept(wr_accept)
  );

  dcf_ptr #(.PW(PW), .SIDE(SIDE_RD)) u_rptr (
    .clk(rd_clk), .rst_n(rd_rst_n), .inc(rd_inc), .peer_sync(wq_gray),
    .bin_q(r_bin), .gray_q(r_gray), .flag_q(rd_empty), .accept(rd_accept)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(w_gray), .q(wq_gray)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(r_gray), .q(rq_gray)
  );

  dcf_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(wr_accept), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
    .raddr(r_bin[AW-1:0]), .rdata(rd_data)
  );
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
module dcf_fifo_chk
  import dcf_pkg::*;
#(
  parameter int PW    = 5,
  parameter int DEPTH = 16
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          wr_inc,
  input logic          wr_full,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_inc,
  input logic          rd_empty,
  input logic [PW-1:0] w_bin,
  input logic [PW-1:0] w_gray,
  input logic [PW-1:0] r_bin,
  input logic [PW-1:0] r_gray,
  input logic [PW-1:0] wq_gray,
  input logic [PW-1:0] rq_gray
);
  logic [PW-1:0] rq_bin, wq_bin;
  assign rq_bin = PW'(gray_to_bin(32'(rq_gray)));
  assign wq_bin = PW'(gray_to_bin(32'(wq_gray)));

  // R9
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !$stable(w_gray) |-> $countones(w_gray ^ $past(w_gray)) == 1);

  // R9
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !$stable(r_gray) |-> $countones(r_gray ^ $past(r_gray)) == 1);

  // R3
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_inc && wr_full) |=> $stable(w_bin));

  // R4
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_inc && rd_empty) |=> $stable(r_bin));

  // R7
  occupancy_bound_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
    32'(PW'(w_bin - rq_bin)) <= DEPTH);

  // R7
  empty_honest_chk: assert property (@(posedge rd_clk) disable iff (!wr_rst_n || !rd_rst_n)
    !rd_empty |-> (wq_bin != r_bin));
endmodule

bind dcf_fifo dcf_fifo_chk #(.PW(PW), .DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_inc(wr_inc), .wr_full(wr_full),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_inc(rd_inc), .rd_empty(rd_empty),
  .w_bin(w_bin), .w_gray(w_gray), .r_bin(r_bin), .r_gray(r_gray),
  .wq_gray(wq_gray), .rq_gray(rq_gray)
);

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/1ps
module dcf_fifo_tb;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;

  logic              wr_clk = 1'b0, rd_clk = 1'b0;
  logic              wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic              wr_inc = 1'b0, rd_inc = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              wr_full, rd_empty;

  always #2   wr_clk = ~wr_clk;   // 250 MHz
  always #3.5 rd_clk = ~rd_clk;

  dcf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_inc(wr_inc), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_inc(rd_inc),
    .rd_data(rd_data), .rd_empty(rd_empty)
  );

  // Reference model: stored words in order of acceptance.
  logic [DATA_W-1:0] model_q [$];
  int checks = 0, fails = 0;
  int wr_pct = 0, rd_pct = 0;
  int wr_budget = 0, rd_budget = 0;   // -1 means unlimited
  bit wr_force = 0, rd_force = 0;
  bit wr_go, rd_go;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Write-side driver and model update, away from the rising edge.
  always @(negedge wr_clk) begin
    if (!wr_rst_n) begin
      wr_inc = 1'b0;
    end else begin
      // R7: a free entry must really exist when full is low
      if (!wr_full) check(model_q.size() < DEPTH, "R7", "occupancy with full low", model_q.size(), DEPTH - 1);
      wr_go = (wr_budget != 0) && (($urandom % 100) < wr_pct);
      if (wr_go && !wr_full) begin
        wr_inc  = 1'b1;
        wr_data = DATA_W'($urandom);
        model_q.push_back(wr_data);
        if (wr_budget > 0) wr_budget--;
      end else if (wr_force) begin
        wr_inc  = 1'b1;
        wr_data = 8'hEE;
      end else begin
        wr_inc = 1'b0;
      end
    end
  end

  // Read-side driver, data comparison and model update.
  always @(negedge rd_clk) begin
    if (!rd_rst_n) begin
      rd_inc = 1'b0;
    end else begin
      // R7: a stored word must really exist when empty is low
      if (!rd_empty) check(model_q.size() > 0, "R7", "occupancy with empty low", model_q.size(), 1);
      rd_go = (rd_budget != 0) && (($urandom % 100) < rd_pct);
      if (rd_go && !rd_empty) begin
        rd_inc = 1'b1;
        if (model_q.size() > 0) begin
          // R2: order preserved
          check(rd_data == model_q[0], "R2", "read word", rd_data, model_q[0]);
          void'(model_q.pop_front());
        end
        if (rd_budget > 0) rd_budget--;
      end else if (rd_force) begin
        rd_inc = 1'b1;
      end else begin
        rd_inc = 1'b0;
      end
    end
  end

  task automatic do_reset();
    wr_pct = 0; rd_pct = 0; wr_budget = 0; rd_budget = 0;
    wr_force = 0; rd_force = 0;
    repeat (3) @(negedge wr_clk);
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    model_q.delete();
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
    @(negedge wr_clk);
    // R1
    check(wr_full == 1'b0, "R1", "wr_full after reset", wr_full, 0);
    @(negedge rd_clk);
    // R1
    check(rd_empty == 1'b1, "R1", "rd_empty after reset", rd_empty, 1);
  endtask

  initial begin
    int n;
    do_reset();

    // R4: pop attempts on an empty FIFO are discarded
    rd_force = 1; rd_pct = 100; rd_budget = -1;
    repeat (10) begin
      @(negedge rd_clk);
      check(rd_empty == 1'b1, "R4", "rd_empty under forced pops", rd_empty, 1);
    end
    rd_force = 0; rd_pct = 0; rd_budget = 0;
    repeat (3) @(negedge rd_clk);

    // R8: empty-clear latency after a single write
    wr_pct = 100; wr_budget = 1;
    wait (wr_budget == 0);
    wr_pct = 0;
    @(posedge wr_clk);
    @(negedge rd_clk);
    check(rd_empty == 1'b1, "R8", "empty held right after write", rd_empty, 1);
    n = 1;
    while (rd_empty && n < 6) begin
      @(negedge rd_clk);
      n++;
    end
    check(n <= 4, "R8", "read edges until empty clears", n, 4);

    // R6: taking the only word sets empty at once
    rd_pct = 100; rd_budget = 1;
    wait (rd_budget == 0);
    rd_pct = 0;
    @(negedge rd_clk);
    check(rd_empty == 1'b1, "R6", "empty after last pop", rd_empty, 1);
    repeat (6) @(negedge wr_clk);

    // R5: fill to DEPTH with no reads
    wr_pct = 100; wr_budget = DEPTH - 1;
    wait (wr_budget == 0);
    @(posedge wr_clk);
    @(negedge wr_clk);
    check(wr_full == 1'b0, "R5", "full with DEPTH-1 outstanding", wr_full, 0);
    wr_budget = 1;
    wait (wr_budget == 0);
    wr_pct = 0;
    @(posedge wr_clk);
    @(negedge wr_clk);
    check(wr_full == 1'b1, "R5", "full with DEPTH outstanding", wr_full, 1);
    check(model_q.size() == DEPTH, "R5", "model occupancy", model_q.size(), DEPTH);

    // R3: pushes while full are discarded
    wr_force = 1; wr_pct = 100; wr_budget = -1;
    repeat (8) begin
      @(negedge wr_clk);
      check(wr_full == 1'b1, "R3", "full under forced pushes", wr_full, 1);
    end
    wr_force = 0; wr_pct = 0; wr_budget = 0;
    @(negedge wr_clk);
    check(model_q.size() == DEPTH, "R3", "no word added while full", model_q.size(), DEPTH);

    // R8: full-clear latency after a single read
    rd_pct = 100; rd_budget = 1;
    wait (rd_budget == 0);
    rd_pct = 0;
    @(posedge rd_clk);
    @(negedge wr_clk);
    check(wr_full == 1'b1, "R8", "full held right after read", wr_full, 1);
    n = 1;
    while (wr_full && n < 6) begin
      @(negedge wr_clk);
      n++;
    end
    check(n <= 4, "R8", "write edges until full clears", n, 4);

    // Drain: the discarded 0xEE words must not appear (R2, R3)
    rd_pct = 100; rd_budget = -1;
    wait (model_q.size() == 0);
    @(negedge rd_clk);
    // R6
    check(rd_empty == 1'b1, "R6", "empty after drain", rd_empty, 1);
    rd_pct = 0; rd_budget = 0;

    // Mixed traffic, writer faster
    wr_pct = 70; wr_budget = -1; rd_pct = 40; rd_budget = -1;
    repeat (2500) @(negedge wr_clk);
    // Mixed traffic, reader eager
    wr_pct = 25; rd_pct = 95;
    repeat (2500) @(negedge wr_clk);
    // Bursty phase
    for (int k = 0; k < 20; k++) begin
      wr_pct = (k % 2) ? 100 : 5;
      rd_pct = (k % 2) ? 10 : 100;
      repeat (60) @(negedge wr_clk);
    end
    wr_pct = 0; wr_budget = 0; rd_pct = 100;
    wait (model_q.size() == 0);
    repeat (6) @(negedge rd_clk);
    // R6
    check(rd_empty == 1'b1, "R6", "empty after random drain", rd_empty, 1);

    // Reset in mid-life, then traffic again
    do_reset();
    wr_pct = 60; wr_budget = 200; rd_pct = 60; rd_budget = -1;
    wait (wr_budget == 0);
    wr_pct = 0;
    wait (model_q.size() == 0);
    repeat (6) @(negedge rd_clk);
    // R2
    check(model_q.size() == 0 && rd_empty, "R2", "all words delivered after reset", model_q.size(), 0);
    report();
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
    report();
  end
endmodule